// File: doc/BRIEF.md
# Prioritising Interrupt Dispatcher with Claim-and-Jump Entry

This block sits beside a processor core and gathers all of its interrupt request lines, internal and external, in one place. For each source it keeps a priority, an enable and a trigger mode, which is either level or rising edge. From the sources that are pending, enabled and above a programmable threshold it picks a winner. The highest priority wins. When two sources share that priority, the higher ID wins. While the global enable is set, it signals the winner to the core on a request/acknowledge pair.

The block has two dispatch styles. In the first, the address handed to the core is a per-source slot in a handler table: the table base plus four bytes for each step of the ID. In the second, every request sends the core to one shared entry stub. That stub saves context and then reads a claim register. Each read returns the table slot of the current winner, turns global interrupts back on and consumes an edge-latched request, all in one step. The stub can loop on this read until it returns zero.

On acknowledge, the block records the cause ID and the interrupted return address, and it clears the global enable. An exit strobe sets the global enable again, and the recorded cause and return address remain on dedicated outputs for the core to restore. Configuration goes through a simple single-cycle register bus.

Top module: `clic_dispatch`

## Requirements
- R1: After reset, irq_req is 0, the global enable (register 4, bit 0) reads 0, a claim read (register 3) returns 0, and every source is disabled with priority 0 and level mode.
- R2: A level-mode source counts as pending exactly while its input is high, and a claim read does not clear it (pending status is bit 10 of its source register at address 16+ID).
- R3: An edge-mode source (bit 9 of its source register) latches pending on a 0-to-1 input transition and stays pending after the input falls. The latch is cleared by a claim of that source, by an acknowledge of that source in table mode, or by a write to that source's register.
- R4: The winner is the source that is pending, enabled (bit 8) and has priority (bits PRIO_W-1:0) strictly above the threshold (register 0). The highest priority wins, and a tie goes to the higher ID.
- R5: irq_req is high exactly when the global enable is set and some source is eligible. irq_id shows the winning ID.
- R6: In table mode, irq_addr equals the table base (register 1) plus 4 times the winning ID.
- R7: When bit 0 of the shared-entry register (register 2) is 1, irq_addr is that register's value with bit 0 cleared, for every winner.
- R8: A claim read with an eligible source returns base plus 4 times the winner's ID and sets the global enable. With no eligible source it returns 0 and leaves the global enable unchanged.
- R9: irq_ack while irq_req clears the global enable and records the winner's ID on ctx_cause and ret_pc on ctx_pc. irq_exit sets the global enable again.
- R10: ID 0 means "none". Input 0 never raises a request, whatever its configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NIRQ | Request lines, bit i for source i |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_req | output | 1 | Interrupt request to the core |
| irq_id | output | IDW | Winning source ID |
| irq_addr | output | 32 | Address the core branches to |
| irq_ack | input | 1 | Core takes the request |
| ret_pc | input | 32 | Return address captured on acknowledge |
| irq_exit | input | 1 | Core leaves the handler |
| gie | output | 1 | Global interrupt enable |
| ctx_cause | output | IDW | Recorded cause ID |
| ctx_pc | output | 32 | Recorded return address |

## Verification
The bench uses the default build: eight sources, so that IDs 0 to 7 and the full three-bit ID field are covered, and three-bit priorities. With so few priority levels, ties between random configurations happen often, which exercises the higher-ID rule on most reconfigurations. A random threshold between 0 and 7 also sometimes masks every source. Edge and level sources are mixed in the same random windows, so latched and live pending states compete in one selection.

// File: rtl/clic_dispatch.sv
module clic_dispatch #(
  parameter int NIRQ   = 8,
  parameter int PRIO_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NIRQ-1:0]         irq_in,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [7:0]              bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    irq_req,
  output logic [$clog2(NIRQ)-1:0] irq_id,
  output logic [31:0]             irq_addr,
  input  logic                    irq_ack,
  input  logic [31:0]             ret_pc,
  input  logic                    irq_exit,
  output logic                    gie,
  output logic [$clog2(NIRQ)-1:0] ctx_cause,
  output logic [31:0]             ctx_pc
);
  localparam int IDW = $clog2(NIRQ);
  localparam logic [7:0] NIRQ8 = 8'(NIRQ);

  logic [PRIO_W-1:0] prio [NIRQ];
  logic [NIRQ-1:0]   ien, edg, pend_e, prev, pend, elig, clr;
  logic [31:0]       vbase, entry, pc_q;
  logic [PRIO_W-1:0] thr, best_p;
  logic [IDW-1:0]    best_id, cause_q;
  logic              gie_q, have, wr, rd_claim, claim_take, take, nonvec, src_hit;
  logic [7:0]        sidx_full;
  logic [IDW-1:0]    sidx;
  logic [31:0]       vec_of;
  logic              unused_bits;

  assign wr         = bus_valid & bus_write;
  assign rd_claim   = bus_valid & ~bus_write & (bus_addr == 8'd3);
  assign sidx_full  = bus_addr - 8'd16;
  assign src_hit    = (bus_addr >= 8'd16) && (sidx_full < NIRQ8);
  assign sidx       = sidx_full[IDW-1:0];
  assign nonvec     = entry[0];
  assign pend       = (edg & pend_e) | (~edg & irq_in);
  assign unused_bits = ^bus_wdata;

  always_comb begin
    elig = '0;
    for (int i = 1; i < NIRQ; i++)
      elig[i] = pend[i] & ien[i] & (prio[i] > thr);
  end

  always_comb begin
    best_id = '0;
    best_p  = '0;
    for (int i = 1; i < NIRQ; i++)
      if (elig[i] && prio[i] >= best_p) begin
        best_p  = prio[i];
        best_id = IDW'(i);
      end
  end

  assign have       = |elig;
  assign vec_of     = vbase + {{(30-IDW){1'b0}}, best_id, 2'b00};
  assign claim_take = rd_claim & have;
  assign take       = irq_ack & irq_req;

  always_comb begin
    clr = '0;
    if (claim_take || (take && !nonvec)) clr[best_id] = 1'b1;
    if (wr && src_hit) clr[sidx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev   <= '0;
      pend_e <= '0;
    end else begin
      prev   <= irq_in;
      pend_e <= (pend_e & ~clr) | (irq_in & ~prev);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vbase <= '0; entry <= '0; thr <= '0; ien <= '0; edg <= '0;
      for (int i = 0; i < NIRQ; i++) prio[i] <= '0;
    end else if (wr) begin
      case (bus_addr)
        8'd0: thr   <= bus_wdata[PRIO_W-1:0];
        8'd1: vbase <= bus_wdata;
        8'd2: entry <= bus_wdata;
        default:
          if (src_hit) begin
            prio[sidx] <= bus_wdata[PRIO_W-1:0];
            ien[sidx]  <= bus_wdata[8];
            edg[sidx]  <= bus_wdata[9];
          end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q <= 1'b0; cause_q <= '0; pc_q <= '0;
    end else begin
      if (wr && bus_addr == 8'd4) gie_q <= bus_wdata[0];
      if (irq_exit) gie_q <= 1'b1;
      if (take) begin
        gie_q   <= 1'b0;
        cause_q <= best_id;
        pc_q    <= ret_pc;
      end
      if (claim_take) gie_q <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      8'd0:    bus_rdata = 32'(thr);
      8'd1:    bus_rdata = vbase;
      8'd2:    bus_rdata = entry;
      8'd3:    bus_rdata = have ? vec_of : 32'd0;
      8'd4:    bus_rdata = {31'd0, gie_q};
      8'd5:    bus_rdata = 32'(cause_q);
      8'd6:    bus_rdata = pc_q;
      default: bus_rdata = src_hit ? {21'd0, pend[sidx], edg[sidx], ien[sidx], 8'(prio[sidx])} : 32'd0;
    endcase
  end

  assign irq_req   = gie_q & have;
  assign irq_id    = best_id;
  assign irq_addr  = nonvec ? {entry[31:1], 1'b0} : vec_of;
  assign gie       = gie_q;
  assign ctx_cause = cause_q;
  assign ctx_pc    = pc_q;

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !gie && !irq_req);
  a_r5_req_id_nonzero: assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> irq_id != '0);
  a_r8_claim_enables: assert property (@(posedge clk) disable iff (!rst_n) (rd_claim && have) |=> gie);
  a_r9_ack_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && !rd_claim) |=> !gie);
  a_r9_exit_unmasks: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_exit && !irq_ack && !(wr && bus_addr == 8'd4)) |=> gie);
  a_r4_above_threshold: assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> prio[irq_id] > thr);
  generate
    for (genvar g = 1; g < NIRQ; g++) begin : g_edge
      a_r3_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in[g] && !prev[g]) |=> pend_e[g]);
    end
  endgenerate
endmodule

// File: tb/clic_dispatch_tb.sv
`timescale 1ns/1ps
module clic_dispatch_tb;
  localparam int NIRQ = 8;
  localparam int PW = 3;

  logic clk = 0, rst_n = 0;
  logic [NIRQ-1:0] irq_in = '0;
  logic bus_valid = 0, bus_write = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, irq_addr, ret_pc = '0, ctx_pc;
  logic irq_req, irq_ack = 0, irq_exit = 0, gie;
  logic [2:0] irq_id, ctx_cause;

  int checks = 0, fails = 0;
  logic [31:0] rd;

  clic_dispatch #(.NIRQ(NIRQ), .PRIO_W(PW)) u_dut (
    .clk, .rst_n, .irq_in, .bus_valid, .bus_write, .bus_addr, .bus_wdata, .bus_rdata,
    .irq_req, .irq_id, .irq_addr, .irq_ack, .ret_pc, .irq_exit, .gie, .ctx_cause, .ctx_pc);

  always #10 clk = ~clk;

  logic [PW-1:0] m_prio [NIRQ];
  logic [NIRQ-1:0] m_en, m_edge, m_pe, m_prev;
  logic [PW-1:0] m_thr;
  logic [31:0] m_base;

  function automatic int best(input logic [NIRQ-1:0] pend);
    int b = 0; int bp = -1;
    for (int i = 1; i < NIRQ; i++)
      if (pend[i] && m_en[i] && m_prio[i] > m_thr && int'(m_prio[i]) >= bp) begin
        bp = int'(m_prio[i]); b = i;
      end
    return b;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_valid = 0; bus_write = 0;
  endtask

  task automatic rdr(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_valid = 0;
  endtask

  task automatic ack(input logic [31:0] pc);
    @(negedge clk); irq_ack = 1; ret_pc = pc;
    @(posedge clk); #1 irq_ack = 0;
  endtask

  task automatic leave();
    @(negedge clk); irq_exit = 1;
    @(posedge clk); #1 irq_exit = 0;
  endtask

  task automatic settle();
    @(negedge clk); #2;
  endtask

  initial begin
    #4_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    settle();
    chk("R1 irq_req", {31'd0, irq_req}, 0);
    rdr(8'd4, rd); chk("R1 gie", rd, 0);
    rdr(8'd3, rd); chk("R1 claim empty", rd, 0);
    rdr(8'd19, rd); chk("R1 src cfg", rd, 0);

    wr(8'd1, 32'h1000);
    wr(8'd19, 32'h102);
    wr(8'd21, 32'h302);
    wr(8'd22, 32'h101);
    wr(8'd4, 1);
    @(negedge clk); irq_in[3] = 1;
    settle();
    chk("R5 req", {31'd0, irq_req}, 1);
    chk("R6 id", {29'd0, irq_id}, 3);
    chk("R6 addr", irq_addr, 32'h100C);

    @(negedge clk); irq_in[5] = 1;
    @(negedge clk); irq_in[5] = 0;
    #2;
    chk("R4 tie to higher id", {29'd0, irq_id}, 5);
    repeat (3) settle();
    chk("R3 edge held after fall", {29'd0, irq_id}, 5);

    wr(8'd0, 2);
    settle();
    chk("R4 threshold masks", {31'd0, irq_req}, 0);
    wr(8'd0, 0);

    ack(32'hABC0);
    settle();
    chk("R9 gie cleared", {31'd0, gie}, 0);
    chk("R9 cause", {29'd0, ctx_cause}, 5);
    chk("R9 pc", ctx_pc, 32'hABC0);
    rdr(8'd21, rd); chk("R3 ack clears edge", {31'd0, rd[10]}, 0);
    rdr(8'd19, rd); chk("R2 level pending", {31'd0, rd[10]}, 1);
    leave();
    settle();
    chk("R9 exit gie", {31'd0, gie}, 1);
    chk("R6 next id", {29'd0, irq_id}, 3);

    wr(8'd2, 32'h2001);
    settle();
    chk("R7 common entry", irq_addr, 32'h2000);
    ack(32'h4440);
    @(negedge clk); irq_in[5] = 1;
    @(negedge clk); irq_in[5] = 0;
    rdr(8'd3, rd); chk("R8 claim edge src", rd, 32'h1014);
    settle();
    chk("R8 claim sets gie", {31'd0, gie}, 1);
    rdr(8'd21, rd); chk("R3 claim clears edge", {31'd0, rd[10]}, 0);
    rdr(8'd3, rd); chk("R8 claim level src", rd, 32'h100C);
    rdr(8'd19, rd); chk("R2 claim keeps level", {31'd0, rd[10]}, 1);
    @(negedge clk); irq_in[3] = 0;
    wr(8'd4, 0);
    rdr(8'd3, rd); chk("R8 claim none", rd, 0);
    settle();
    chk("R8 none keeps gie", {31'd0, gie}, 0);

    wr(8'd2, 0);
    wr(8'd16, 32'h307);
    @(negedge clk); irq_in[0] = 1;
    wr(8'd4, 1);
    settle();
    chk("R10 id0 ignored", {31'd0, irq_req}, 0);
    @(negedge clk); irq_in[0] = 0; irq_in[6] = 1;
    wr(8'd4, 0);
    settle();
    chk("R5 gated by gie", {31'd0, irq_req}, 0);
    wr(8'd4, 1);
    settle();
    chk("R5 req id6", {29'd0, irq_id}, 6);

    @(negedge clk); irq_in = '0;
    m_pe = '0; m_prev = '0;
    for (int s = 0; s < 40; s++) begin
      m_base = $urandom & 32'hFFFF_FF00;
      m_thr = PW'($urandom);
      if ($urandom_range(0, 3) == 0) m_thr = 0;
      wr(8'd1, m_base);
      wr(8'd0, 32'(m_thr));
      m_prio[0] = 0; m_en[0] = 0; m_edge[0] = 0;
      for (int i = 1; i < NIRQ; i++) begin
        m_prio[i] = PW'($urandom); m_en[i] = 1'($urandom); m_edge[i] = 1'($urandom);
        wr(8'(16 + i), {22'd0, m_edge[i], m_en[i], 5'd0, m_prio[i]});
      end
      m_pe = '0; m_prev = irq_in;
      for (int c = 0; c < 50; c++) begin
        @(negedge clk);
        irq_in = NIRQ'($urandom);
        #2;
        begin
          logic [NIRQ-1:0] p;
          int b;
          p = (m_edge & m_pe) | (~m_edge & irq_in);
          b = best(p);
          chk("R4 random req", {31'd0, irq_req}, {31'd0, b != 0});
          if (b != 0) begin
            chk("R4 random id", {29'd0, irq_id}, 32'(b));
            chk("R6 random addr", irq_addr, m_base + 32'(4 * b));
          end
        end
        @(posedge clk); #1;
        m_pe = m_pe | (irq_in & ~m_prev);
        m_prev = irq_in;
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule